// File: doc/BRIEF.md
# Gate-Drive Fault Supervisor

This block guards a three-phase half-bridge gate driver. It takes the digital result of an over-current comparator, one undervoltage flag for the logic supply and one undervoltage flag for each of the three floating high-side supplies. From these it makes three outputs: a global shutdown that turns off all six gate commands, a per-phase block for each high-side output, and an active-low fault line that reports the shutdown.

The over-current input is ignored for a short window after any gate output switches on, so that switching noise cannot cause a trip. The same window also runs right after reset. An accepted trip is latched. No reset pin clears it. It clears only when all three low-side command inputs have stayed in their off level for an unbroken run of clock cycles. Undervoltage lockout follows its flag and releases by itself.

Top module: `fault_supervisor`

## Requirements
- R1: While reset is active, `kill_all_o` is 1, `fault_n_o` is 0, every bit of `hs_block_o` is 1, and the over-current latch is clear.
- R2: If `trip_i` is 1 on a clock edge outside the blanking window, the over-current latch sets on that edge. From the next sample on, `kill_all_o` is 1 and `fault_n_o` is 0.
- R3: A 0-to-1 change on any bit of `gate_on_i` opens a blanking window. The window covers the clock edge where the rise is first seen and the following BLANK_CYC edges. A trip during the window is ignored. A falling gate edge opens no window.
- R4: After reset is released, the first BLANK_CYC clock edges are blanked. A trip held through that window latches once the window has passed.
- R5: Once set, the latch stays set after `trip_i` returns to 0, for as long as the clear condition of R6 is not met.
- R6: The clear condition is that all three bits of `ls_off_i` are 1 (each low side commanded off). The latch clears on the CLEAR_CYC-th consecutive clock edge at which this condition holds while the latch is set. If only some of the bits are 1, the latch does not clear.
- R7: A single clock edge where any bit of `ls_off_i` is 0 restarts the clear count from zero.
- R8: An unblanked trip during a clear run keeps the latch set and restarts the clear count.
- R9: When `uv_logic_i` is 1, `kill_all_o` is 1 and `fault_n_o` is 0 one cycle later. Both release one cycle after the flag falls, and no clear sequence is needed.
- R10: `hs_block_o[i]` follows `uv_float_i[i]` with one cycle of delay. A floating-supply undervoltage asserts neither `kill_all_o` nor the fault line.
- R11: When an undervoltage lockout ends, the over-current latch is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_i | input | 1 | Over-current comparator result, 1 = over-current |
| uv_logic_i | input | 1 | Logic supply undervoltage flag, 1 = low |
| uv_float_i | input | NPH | Per-phase floating supply undervoltage flags |
| gate_on_i | input | 2*NPH | Current state of the six gate outputs, 1 = on |
| ls_off_i | input | NPH | Low-side command inputs, 1 = commanded off |
| kill_all_o | output | 1 | Global shutdown of all gate outputs |
| hs_block_o | output | NPH | Per-phase high-side output block |
| fault_n_o | output | 1 | Active-low fault indication |

## Verification
The bench drives trip pulses at four kinds of time: inside the post-reset window, just past it, inside a window opened by a gate rise (including the rise cycle itself), and inside the quiet period after a rise. Together these show whether the blanking window starts and ends at the right edge.

For the clear logic, the bench tries four low-side patterns: fully off, partially off, fully off with a one-cycle break, and fully off with a trip part-way through. These separate a correct timer from one that counts non-consecutive cycles, one that accepts a partial off state, and one that lets a clear win over a new trip. Undervoltage pulses on the logic supply and on each floating supply show which outputs each flag may touch. Ending a lockout while the trip latch is set shows that the two causes are held apart.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  // Count of consecutive qualifying edges: advance or restart.
  function automatic int hold_next(input int held, input logic go);
    return go ? held + 1 : 0;
  endfunction

  // Blanking window remaining: reload on a switching event, else count down to zero.
  function automatic int blank_next(input int left, input logic load, input int reload);
    if (load) return reload;
    return (left > 0) ? left - 1 : 0;
  endfunction

endpackage

// File: rtl/fsup_blank.sv
module fsup_blank #(
  parameter int N_GATE    = 6,
  parameter int BLANK_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GATE-1:0] gate_on_i,
  output logic              rise_o,
  output logic              blank_o
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic [N_GATE-1:0] gate_q;
  logic [BW-1:0]     left_q;

  assign rise_o  = |(gate_on_i & ~gate_q);
  assign blank_o = rise_o | (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      left_q <= BW'(BLANK_CYC);
    end else begin
      gate_q <= gate_on_i;
      left_q <= BW'(fsup_pkg::blank_next(int'(left_q), rise_o, BLANK_CYC));
    end
  end
endmodule

// File: rtl/fsup_clear.sv
module fsup_clear #(
  parameter int NPH       = 3,
  parameter int CLEAR_CYC = 900
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           latched_i,
  input  logic           set_i,
  input  logic [NPH-1:0] ls_off_i,
  output logic           all_off_o,
  output logic           fire_o
);
  localparam int CW = $clog2(CLEAR_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          cond;

  assign all_off_o = &ls_off_i;
  assign cond      = latched_i & all_off_o;
  assign fire_o    = cond && (cnt_q == CW'(CLEAR_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CW'(fsup_pkg::hold_next(int'(cnt_q), cond & ~fire_o & ~set_i));
  end
endmodule

// File: rtl/fsup_uv.sv
module fsup_uv #(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           uv_logic_i,
  input  logic [NPH-1:0] uv_float_i,
  output logic           uvl_o,
  output logic [NPH-1:0] uvf_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uvl_o <= 1'b1;
      uvf_o <= '1;
    end else begin
      uvl_o <= uv_logic_i;
      uvf_o <= uv_float_i;
    end
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int NPH       = 3,
  parameter int BLANK_CYC = 40,
  parameter int CLEAR_CYC = 900
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip_i,
  input  logic             uv_logic_i,
  input  logic [NPH-1:0]   uv_float_i,
  input  logic [2*NPH-1:0] gate_on_i,
  input  logic [NPH-1:0]   ls_off_i,
  output logic             kill_all_o,
  output logic [NPH-1:0]   hs_block_o,
  output logic             fault_n_o
);
  localparam int N_GATE = 2 * NPH;

  // Named internal events for the checker.
  logic rise_w, blank_w, set_w, fire_w, all_off_w, oc_q, uvl_w;
  logic [NPH-1:0] uvf_w;

  fsup_blank #(.N_GATE(N_GATE), .BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .gate_on_i(gate_on_i),
    .rise_o(rise_w), .blank_o(blank_w)
  );

  assign set_w = trip_i & ~blank_w;

  fsup_clear #(.NPH(NPH), .CLEAR_CYC(CLEAR_CYC)) u_clear (
    .clk(clk), .rst_n(rst_n), .latched_i(oc_q), .set_i(set_w),
    .ls_off_i(ls_off_i), .all_off_o(all_off_w), .fire_o(fire_w)
  );

  fsup_uv #(.NPH(NPH)) u_uv (
    .clk(clk), .rst_n(rst_n), .uv_logic_i(uv_logic_i), .uv_float_i(uv_float_i),
    .uvl_o(uvl_w), .uvf_o(uvf_w)
  );

  // Over-current latch: set wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      oc_q <= 1'b0;
    else if (set_w)  oc_q <= 1'b1;
    else if (fire_w) oc_q <= 1'b0;
  end

  assign kill_all_o = oc_q | uvl_w;
  assign fault_n_o  = ~(oc_q | uvl_w);
  assign hs_block_o = uvf_w;
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk #(
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trip_i,
  input logic           uv_logic_i,
  input logic [NPH-1:0] uv_float_i,
  input logic           kill_all_o,
  input logic           fault_n_o,
  input logic [NPH-1:0] hs_block_o,
  input logic           rise_w,
  input logic           blank_w,
  input logic           oc_q,
  input logic           all_off_w
);
  assert_trip_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_i && !blank_w) |=> (oc_q && kill_all_o && !fault_n_o));

  assert_rise_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_q) |-> $past(trip_i));

  assert_rise_blanks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |=> blank_w);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_q && !all_off_w) |=> oc_q);

  assert_clear_needs_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_q) |-> $past(all_off_w));

  assert_uv_logic_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uv_logic_i |=> (kill_all_o && !fault_n_o));

  assert_uv_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hs_block_o == $past(uv_float_i)));
endmodule

bind fault_supervisor fault_supervisor_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .uv_logic_i(uv_logic_i),
  .uv_float_i(uv_float_i), .kill_all_o(kill_all_o), .fault_n_o(fault_n_o),
  .hs_block_o(hs_block_o), .rise_w(rise_w), .blank_w(blank_w),
  .oc_q(oc_q), .all_off_w(all_off_w)
);

// File: tb/sim_fault_supervisor.sv
module sim_fault_supervisor;
  localparam int NPH = 3;
  localparam int B   = 40;
  localparam int C   = 900;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic trip = 1'b0, uvl = 1'b0;
  logic [NPH-1:0] uvf = '0, ls = '0;
  logic [2*NPH-1:0] gates = '0;
  logic kill, fault_n;
  logic [NPH-1:0] hsb;

  always #5 clk = ~clk;

  fault_supervisor #(.NPH(NPH), .BLANK_CYC(B), .CLEAR_CYC(C)) u0 (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .uv_logic_i(uvl), .uv_float_i(uvf),
    .gate_on_i(gates), .ls_off_i(ls), .kill_all_o(kill), .hs_block_o(hsb),
    .fault_n_o(fault_n)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference: cycles since last switching rise, held-off run length.
  int since_rise = 0, held = 0;
  bit m_oc = 0, m_uvl = 1;
  logic [NPH-1:0] m_uvf = '1;
  logic [2*NPH-1:0] m_prev = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      since_rise = 0; held = 0; m_oc = 0; m_uvl = 1; m_uvf = '1; m_prev = '0;
    end else begin
      bit rise, blanked, take;
      rise = 1'b0;
      for (int i = 0; i < 2*NPH; i++) if (gates[i] && !m_prev[i]) rise = 1'b1;
      blanked = rise || (since_rise < B);
      take = trip && !blanked;
      if (m_oc && (ls == '1)) held = held + 1; else held = 0;
      if (take) begin m_oc = 1; held = 0; end
      else if (held >= C) begin m_oc = 0; held = 0; end
      since_rise = rise ? 0 : ((since_rise < B) ? since_rise + 1 : since_rise);
      m_prev = gates;
      m_uvl = uvl;
      m_uvf = uvf;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit ek;
      ek = m_oc | m_uvl;
      n_cmp++;
      if (kill !== ek || fault_n !== !ek || hsb !== m_uvf) begin
        n_bad++;
        $display("FAIL %s model: kill=%0d/%0d fault_n=%0d/%0d hs=%0d/%0d (actual/expected)",
                 tag, kill, ek, fault_n, !ek, hsb, m_uvf);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trip();
    trip = 1'b1; step(1); trip = 1'b0;
  endtask

  task automatic clear_latch();
    ls = '1; step(C + 2); ls = '0; step(2);
  endtask

  initial begin
    #2 rst_n = 1'b0;
    step(3);
    tag = "R1";
    chk(kill == 1'b1, "R1 kill", kill, 1);
    chk(fault_n == 1'b0, "R1 fault_n", fault_n, 0);
    chk(hsb == 3'b111, "R1 hs_block", hsb, 7);

    tag = "R4";
    trip = 1'b1;
    rst_n = 1'b1;
    step(20);
    chk(kill == 1'b0, "R4 trip inside post-reset window", kill, 0);
    step(25);
    chk(kill == 1'b1, "R4 trip after window", kill, 1);
    chk(fault_n == 1'b0, "R4 fault_n", fault_n, 0);

    tag = "R5";
    trip = 1'b0; ls = 3'b000; step(50);
    chk(kill == 1'b1, "R5 latch holds", kill, 1);

    tag = "R6";
    ls = 3'b011; step(C + 20);
    chk(kill == 1'b1, "R6 partial off does not clear", kill, 1);
    ls = 3'b111; step(C - 1);
    chk(kill == 1'b1, "R6 one edge short", kill, 1);
    step(1);
    chk(kill == 1'b0, "R6 cleared on count", kill, 0);
    chk(fault_n == 1'b1, "R6 fault_n released", fault_n, 1);
    ls = 3'b000; step(2);

    tag = "R2";
    pulse_trip();
    chk(kill == 1'b1, "R2 latch next cycle", kill, 1);
    chk(fault_n == 1'b0, "R2 fault_n", fault_n, 0);

    tag = "R7";
    ls = 3'b111; step(500);
    ls = 3'b110; step(1);
    ls = 3'b111; step(C - 1);
    chk(kill == 1'b1, "R7 break restarts count", kill, 1);
    step(1);
    chk(kill == 1'b0, "R7 clear after full run", kill, 0);
    ls = 3'b000; step(2);

    tag = "R8";
    pulse_trip();
    ls = 3'b111; step(600);
    pulse_trip();
    step(C - 1);
    chk(kill == 1'b1, "R8 retrip restarts count", kill, 1);
    step(1);
    chk(kill == 1'b0, "R8 clear after restart", kill, 0);
    ls = 3'b000; step(50);

    tag = "R3";
    gates[2] = 1'b1; step(10);
    pulse_trip(); step(5);
    chk(kill == 1'b0, "R3 trip in rise window ignored", kill, 0);
    gates[4] = 1'b1; trip = 1'b1; step(3); trip = 1'b0; step(2);
    chk(kill == 1'b0, "R3 trip on rise cycle ignored", kill, 0);
    gates[2] = 1'b0; step(B + 5);
    pulse_trip(); step(1);
    chk(kill == 1'b1, "R3 falling edge opens no window", kill, 1);
    clear_latch();

    tag = "R9";
    uvl = 1'b1; step(1);
    chk(kill == 1'b1, "R9 kill", kill, 1);
    chk(fault_n == 1'b0, "R9 fault_n", fault_n, 0);
    step(20);
    uvl = 1'b0; step(1);
    chk(kill == 1'b0, "R9 auto release", kill, 0);
    chk(fault_n == 1'b1, "R9 fault_n release", fault_n, 1);

    tag = "R10";
    uvf = 3'b101; step(1);
    chk(hsb == 3'b101, "R10 hs_block", hsb, 5);
    chk(kill == 1'b0, "R10 no kill", kill, 0);
    chk(fault_n == 1'b1, "R10 no fault", fault_n, 1);
    uvf = 3'b010; step(1);
    chk(hsb == 3'b010, "R10 hs_block", hsb, 2);
    uvf = 3'b000; step(3);

    tag = "R11";
    pulse_trip();
    uvl = 1'b1; step(5);
    uvl = 1'b0; step(5);
    chk(kill == 1'b1, "R11 latch survives UV release", kill, 1);
    clear_latch();
    chk(kill == 1'b0, "R11 cleared by low sides", kill, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule